// File: doc/BRIEF.md
# Authenticated-Cipher Input Parser and Block Packer

This block stands in front of an authenticated-cipher core. Two word streams arrive on it: a public stream carrying instructions, typed segment headers and segment data (nonce, associated data, plaintext, ciphertext, tag), and a secret stream carrying key-load instructions with their key segments. The block decodes the instruction opcode and each segment header. It assembles data bytes into full cipher-width blocks, most significant byte first. It pads the final partial block of each data type, and it hands the core one block at a time with a type code, a last-of-type flag and a per-byte valid mask.

Segment lengths are in bytes and count down as words arrive, so the total size of a message need not be known up front. Several segments of one type are joined into one byte sequence. Header words and associated-data words are also copied to a bypass stream for the output side. A key arriving on the secret stream is only staged there. It becomes the working key when an activate instruction is seen on the public stream.

All streams use valid/ready. A word moves on a cycle where both are high. A producer holds valid and data steady until the word is taken. While a block waits for the core, the public input is not ready, so no word is lost. On words that are copied to the bypass stream, public ready also waits for bypass ready. The secret stream is always ready. Input rules: a segment that is not the last of its type carries a whole number of blocks, and a key segment carries exactly one key.

Top module: `aead_inprep`

## Requirements
- R1: An instruction occupies the top 24 bits of a ceil(24/W)-word group, sent most significant word first. Bits [15:12] are the opcode. Opcode 0010 starts an encrypt message and drives op_decrypt to 0, and 0011 starts a decrypt message and drives it to 1. Reserved codes such as 0000 are ignored, and the next word is read as a fresh instruction.
- R2: A segment header occupies the top 32 bits of its word group. Bits [31:24] hold a message number, [23:20] the type, [17] last-of-type, [16] last-of-input and [15:0] the length in bytes. Types 0001 nonce, 0010 associated data, 0011 plaintext, 0100 ciphertext and 0101 tag are delivered to the core with blk_type equal to that code.
- R3: Data bytes fill the block in arrival order. Byte k lands at blk_data[BLK-1-8k -: 8] with blk_bvalid[BB-1-k] set. A block that fills up before its type ends goes out with all mask bits set and blk_last low.
- R4: The last block of a type has blk_last high. When it is partial, the byte after the data is 0x80 and all later bytes are zero. Word bytes past the segment length are discarded.
- R5: A zero-length segment that is not last of its type makes no block. A zero-length last-of-type segment with no pending bytes makes a block with an all-zero mask, blk_last high and data 0x80 followed by zeros.
- R6: Consecutive segments of one type are joined. A block is closed mid-type only when it is full, and blk_last appears only at the segment marked last-of-type.
- R7: A block on the output holds blk_valid, data, mask, type and last unchanged until blk_ready. pub_ready stays low for that whole time.
- R8: Every header word and every associated-data word appears on the bypass stream in input order. Such a word is taken from the public stream only in the cycle it is taken on the bypass stream.
- R9: A secret-stream instruction with opcode 0100, followed by a type 0110 segment, stages the key. key_out does not change because of it.
- R10: Opcode 0101 on the public stream copies the staged key to key_out and raises key_update for one cycle. key_out changes at no other time.
- R11: After reset, blk_valid, byp_valid, key_update, op_decrypt and key_out are all zero, and pub_ready is high, waiting for an instruction.
- R12: After a segment marked last-of-input has been fully handled, the next public word is read as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pub_data | input | W | Public stream word |
| pub_valid | input | 1 | Public word valid |
| pub_ready | output | 1 | Public word accepted when high with valid |
| sec_data | input | W | Secret stream word |
| sec_valid | input | 1 | Secret word valid |
| sec_ready | output | 1 | Secret word accepted when high with valid |
| blk_data | output | BLK | Padded block to the core |
| blk_bvalid | output | BLK/8 | Per-byte valid mask, MSB is byte 0 |
| blk_type | output | 4 | Segment type code of the block |
| blk_last | output | 1 | Last block of its type |
| blk_valid | output | 1 | Block offered to the core |
| blk_ready | input | 1 | Core takes the block |
| byp_data | output | W | Bypass word |
| byp_valid | output | 1 | Bypass word valid |
| byp_ready | input | 1 | Bypass consumer ready |
| key_out | output | BLK | Working key |
| key_update | output | 1 | One-cycle pulse when key_out is loaded |
| op_decrypt | output | 1 | Current message is a decryption |

## Verification
A block is offered the cycle after its final word is taken: one register sits between the taken word and blk_valid. It stays offered until the core takes it. The bench predicts each block, bypass word and the final key from its own byte-level model of the stream. Each clock it samples the handshakes 1 ns after the falling edge and compares a block or bypass word only in the cycle where both valid and ready are high. The working key is due one cycle after the activate word is taken and the staged key when its segment's last word is taken. Both are compared only after the stream has drained, and key_update pulses are counted every cycle.

// File: rtl/aip_pkg.sv
`timescale 1ns/1ps
package aip_pkg;
  localparam logic [3:0] OPC_ENC  = 4'b0010;
  localparam logic [3:0] OPC_DEC  = 4'b0011;
  localparam logic [3:0] OPC_LOAD = 4'b0100;
  localparam logic [3:0] OPC_ACT  = 4'b0101;

  localparam logic [3:0] TY_NONCE = 4'b0001;
  localparam logic [3:0] TY_AD    = 4'b0010;
  localparam logic [3:0] TY_TAG   = 4'b0101;
  localparam logic [3:0] TY_KEY   = 4'b0110;

  localparam int INSTR_BITS = 24;
  localparam int HDR_FIXED  = 16;

  typedef enum logic [1:0] {P_INS, P_HDR, P_DAT, P_HOLD} pub_st_e;
  typedef enum logic [1:0] {S_INS, S_HDR, S_KEY} sec_st_e;
endpackage

// File: rtl/aip_collect.sv
`timescale 1ns/1ps
// Gathers NW words, most significant first, into one wide value.
module aip_collect #(
  parameter int W  = 32,
  parameter int NW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  output logic            last,
  output logic [NW*W-1:0] word
);
  localparam int CW = (NW > 1) ? $clog2(NW) : 1;
  logic [CW-1:0] cnt_q;

  assign last = (int'(cnt_q) == NW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (push) begin
      if (last)          cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (NW == 1) begin : g_single
      assign word = din;
    end else begin : g_multi
      localparam int SHW = (NW - 1) * W;
      logic [SHW-1:0] sh_q;
      assign word = {sh_q, din};
      if (NW == 2) begin : g_two
        always_ff @(posedge clk) begin
          if (!rst_n)     sh_q <= '0;
          else if (push)  sh_q <= din;
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (!rst_n)     sh_q <= '0;
          else if (push)  sh_q <= {sh_q[SHW-W-1:0], din};
        end
      end
    end
  endgenerate
endmodule

// File: rtl/aip_pack.sv
`timescale 1ns/1ps
// Serial-in parallel-out byte packer with 0x80-then-zero padding.
module aip_pack #(
  parameter int W   = 32,
  parameter int BLK = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [W-1:0]                  din,
  input  logic [$clog2(W/8+1)-1:0]      nb,
  input  logic                          clr,
  output logic [$clog2(BLK/8+1)-1:0]    fill,
  output logic [BLK-1:0]                data_o,
  output logic [BLK/8-1:0]              mask_o
);
  localparam int WB = W / 8;
  localparam int BB = BLK / 8;
  localparam int FW = $clog2(BB + 1);

  logic [BLK-1:0] bq;
  logic [FW-1:0]  fill_q;

  assign fill = fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      bq     <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (wr) begin
      fill_q <= fill_q + FW'(nb);
      for (int i = 0; i < BB; i++) begin
        for (int j = 0; j < WB; j++) begin
          if ((j < int'(nb)) && (int'(fill_q) + j == i))
            bq[BLK-1-8*i -: 8] <= din[W-1-8*j -: 8];
        end
      end
    end
  end

  always_comb begin
    data_o = '0;
    mask_o = '0;
    for (int i = 0; i < BB; i++) begin
      if (i < int'(fill_q)) begin
        data_o[BLK-1-8*i -: 8] = bq[BLK-1-8*i -: 8];
        mask_o[BB-1-i]         = 1'b1;
      end else if (i == int'(fill_q)) begin
        data_o[BLK-1-8*i -: 8] = 8'h80;
      end
    end
  end
endmodule

// File: rtl/aip_keyload.sv
`timescale 1ns/1ps
// Secret-stream side: load-key instruction, key segment, staging register.
module aip_keyload
  import aip_pkg::*;
#(
  parameter int W    = 32,
  parameter int KW   = 128,
  parameter int LENW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  sec_data,
  input  logic          sec_valid,
  output logic          sec_ready,
  output logic [KW-1:0] key_stage
);
  localparam int WB  = W / 8;
  localparam int HB  = HDR_FIXED + LENW;
  localparam int NWI = (INSTR_BITS + W - 1) / W;
  localparam int NWH = (HB + W - 1) / W;
  localparam int IW  = NWI * W;
  localparam int HW  = NWH * W;

  sec_st_e        st_q;
  logic [LENW-1:0] rem_q;
  logic           is_key_q;
  logic [KW-1:0]  sh_q;
  logic [KW-1:0]  stage_q;
  logic           acc;
  logic           i_last, h_last;
  logic [IW-1:0]  i_word;
  logic [HW-1:0]  h_word;
  logic [KW-1:0]  sh_next;

  assign sec_ready = 1'b1;
  assign acc       = sec_valid & sec_ready;
  assign key_stage = stage_q;
  assign sh_next   = {sh_q[KW-W-1:0], sec_data};

  aip_collect #(.W(W), .NW(NWI)) u_ins (
    .clk(clk), .rst_n(rst_n), .push(acc && st_q == S_INS),
    .din(sec_data), .last(i_last), .word(i_word));

  aip_collect #(.W(W), .NW(NWH)) u_hdr (
    .clk(clk), .rst_n(rst_n), .push(acc && st_q == S_HDR),
    .din(sec_data), .last(h_last), .word(h_word));

  logic unused_sec;
  assign unused_sec = ^{i_word[IW-1 -: 8], i_word[IW-13 -: 12], i_word[IW-INSTR_BITS-1:0] & '0,
                        h_word[HW-1 -: 8], h_word[HW-13 -: 4], h_word[HW-HB-1:0] & '0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_INS;
      rem_q    <= '0;
      is_key_q <= 1'b0;
      sh_q     <= '0;
      stage_q  <= '0;
    end else if (acc) begin
      case (st_q)
        S_INS: if (i_last && i_word[IW-9 -: 4] == OPC_LOAD) st_q <= S_HDR;
        S_HDR: if (h_last) begin
          is_key_q <= (h_word[HW-9 -: 4] == TY_KEY);
          rem_q    <= h_word[HW-17 -: LENW];
          st_q     <= (h_word[HW-17 -: LENW] != '0) ? S_KEY : S_INS;
        end
        S_KEY: begin
          sh_q <= sh_next;
          if (rem_q <= LENW'(WB)) begin
            rem_q <= '0;
            st_q  <= S_INS;
            if (is_key_q) stage_q <= sh_next;
          end else begin
            rem_q <= rem_q - LENW'(WB);
          end
        end
        default: st_q <= S_INS;
      endcase
    end
  end
endmodule

// File: rtl/aead_inprep.sv
`timescale 1ns/1ps
module aead_inprep
  import aip_pkg::*;
#(
  parameter int W    = 32,
  parameter int BLK  = 128,
  parameter int LENW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     pub_data,
  input  logic             pub_valid,
  output logic             pub_ready,
  input  logic [W-1:0]     sec_data,
  input  logic             sec_valid,
  output logic             sec_ready,
  output logic [BLK-1:0]   blk_data,
  output logic [BLK/8-1:0] blk_bvalid,
  output logic [3:0]       blk_type,
  output logic             blk_last,
  output logic             blk_valid,
  input  logic             blk_ready,
  output logic [W-1:0]     byp_data,
  output logic             byp_valid,
  input  logic             byp_ready,
  output logic [BLK-1:0]   key_out,
  output logic             key_update,
  output logic             op_decrypt
);
  localparam int WB  = W / 8;
  localparam int BB  = BLK / 8;
  localparam int NBW = $clog2(WB + 1);
  localparam int FW  = $clog2(BB + 1);
  localparam int HB  = HDR_FIXED + LENW;
  localparam int NWI = (INSTR_BITS + W - 1) / W;
  localparam int NWH = (HB + W - 1) / W;
  localparam int IW  = NWI * W;
  localparam int HW  = NWH * W;

  pub_st_e         st_q, ret_q;
  logic [3:0]      ty_q;
  logic            eot_q, eoi_q;
  logic [LENW-1:0] rem_q;
  logic            bv_q, bl_q, dec_q, kupd_q;
  logic [BLK-1:0]  key_q;
  logic [BLK-1:0]  key_stage;

  logic            acc, is_ad, is_blk, h_is_blk, seg_end;
  logic            i_last, h_last;
  logic [IW-1:0]   i_word;
  logic [HW-1:0]   h_word;
  logic [3:0]      i_op, h_ty;
  logic            h_eot, h_eoi;
  logic [LENW-1:0] h_len;
  logic [NBW-1:0]  nb;
  logic [FW-1:0]   fill;
  logic [FW:0]     newfill;

  assign is_ad    = (ty_q == TY_AD);
  assign is_blk   = (ty_q >= TY_NONCE) && (ty_q <= TY_TAG);
  assign i_op     = i_word[IW-9 -: 4];
  assign h_ty     = h_word[HW-9 -: 4];
  assign h_eot    = h_word[HW-15];
  assign h_eoi    = h_word[HW-16];
  assign h_len    = h_word[HW-17 -: LENW];
  assign h_is_blk = (h_ty >= TY_NONCE) && (h_ty <= TY_TAG);
  assign nb       = (rem_q < LENW'(WB)) ? NBW'(rem_q) : NBW'(WB);
  assign seg_end  = (rem_q <= LENW'(WB));
  assign newfill  = {1'b0, fill} + (FW+1)'(nb);

  logic unused_pub;
  assign unused_pub = ^{i_word[IW-1 -: 8], i_word[IW-13 -: 12], i_word[IW-INSTR_BITS-1:0] & '0,
                        h_word[HW-1 -: 8], h_word[HW-13 -: 2], h_word[HW-HB-1:0] & '0};

  always_comb begin
    case (st_q)
      P_INS:   pub_ready = 1'b1;
      P_HDR:   pub_ready = byp_ready;
      P_DAT:   pub_ready = is_ad ? byp_ready : 1'b1;
      default: pub_ready = 1'b0;
    endcase
  end

  assign acc        = pub_valid & pub_ready;
  assign byp_valid  = pub_valid & ((st_q == P_HDR) | ((st_q == P_DAT) & is_ad));
  assign byp_data   = pub_data;
  assign blk_valid  = bv_q;
  assign blk_last   = bl_q;
  assign blk_type   = ty_q;
  assign key_out    = key_q;
  assign key_update = kupd_q;
  assign op_decrypt = dec_q;

  aip_collect #(.W(W), .NW(NWI)) u_ins (
    .clk(clk), .rst_n(rst_n), .push(acc && st_q == P_INS),
    .din(pub_data), .last(i_last), .word(i_word));

  aip_collect #(.W(W), .NW(NWH)) u_hdr (
    .clk(clk), .rst_n(rst_n), .push(acc && st_q == P_HDR),
    .din(pub_data), .last(h_last), .word(h_word));

  aip_pack #(.W(W), .BLK(BLK)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .wr(acc && st_q == P_DAT && is_blk), .din(pub_data), .nb(nb),
    .clr(bv_q && blk_ready), .fill(fill),
    .data_o(blk_data), .mask_o(blk_bvalid));

  aip_keyload #(.W(W), .KW(BLK), .LENW(LENW)) u_key (
    .clk(clk), .rst_n(rst_n), .sec_data(sec_data), .sec_valid(sec_valid),
    .sec_ready(sec_ready), .key_stage(key_stage));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= P_INS;
      ret_q  <= P_INS;
      ty_q   <= '0;
      eot_q  <= 1'b0;
      eoi_q  <= 1'b0;
      rem_q  <= '0;
      bv_q   <= 1'b0;
      bl_q   <= 1'b0;
      dec_q  <= 1'b0;
      kupd_q <= 1'b0;
      key_q  <= '0;
    end else begin
      kupd_q <= 1'b0;
      case (st_q)
        P_INS: if (acc && i_last) begin
          case (i_op)
            OPC_ENC: begin dec_q <= 1'b0; st_q <= P_HDR; end
            OPC_DEC: begin dec_q <= 1'b1; st_q <= P_HDR; end
            OPC_ACT: begin key_q <= key_stage; kupd_q <= 1'b1; end
            default: ;
          endcase
        end
        P_HDR: if (acc && h_last) begin
          ty_q  <= h_ty;
          eot_q <= h_eot;
          eoi_q <= h_eoi;
          rem_q <= h_len;
          if (h_len != '0) begin
            st_q <= P_DAT;
          end else if (h_is_blk && h_eot) begin
            bv_q  <= 1'b1;
            bl_q  <= 1'b1;
            st_q  <= P_HOLD;
            ret_q <= h_eoi ? P_INS : P_HDR;
          end else begin
            st_q <= h_eoi ? P_INS : P_HDR;
          end
        end
        P_DAT: if (acc) begin
          rem_q <= rem_q - LENW'(nb);
          if (is_blk && ((newfill == (FW+1)'(BB)) || (seg_end && eot_q))) begin
            bv_q  <= 1'b1;
            bl_q  <= seg_end && eot_q;
            st_q  <= P_HOLD;
            ret_q <= !seg_end ? P_DAT : (eoi_q ? P_INS : P_HDR);
          end else if (seg_end) begin
            st_q <= eoi_q ? P_INS : P_HDR;
          end
        end
        default: if (blk_ready) begin
          bv_q <= 1'b0;
          bl_q <= 1'b0;
          st_q <= ret_q;
        end
      endcase
    end
  end
endmodule

// File: rtl/aip_chk.sv
`timescale 1ns/1ps
module aip_chk #(
  parameter int BLK = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pub_valid,
  input logic             pub_ready,
  input logic [BLK-1:0]   blk_data,
  input logic [BLK/8-1:0] blk_bvalid,
  input logic [3:0]       blk_type,
  input logic             blk_last,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic             byp_valid,
  input logic             byp_ready,
  input logic [BLK-1:0]   key_out,
  input logic             key_update
);
  logic [BLK/8-1:0] inv_m;
  assign inv_m = ~blk_bvalid;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_bvalid)
                                && $stable(blk_type) && $stable(blk_last));
  // R7
  no_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !pub_ready);
  // R8
  byp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid && byp_ready |-> pub_valid && pub_ready);
  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> ((inv_m & (inv_m + 1'b1)) == '0));
  // R3
  full_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_last |-> (&blk_bvalid));
  // R5
  empty_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && (blk_bvalid == '0) |-> blk_last && (blk_data[BLK-1 -: 8] == 8'h80));
  // R10
  key_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_out) |-> key_update);
endmodule

bind aead_inprep aip_chk #(.BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .pub_valid(pub_valid), .pub_ready(pub_ready),
  .blk_data(blk_data), .blk_bvalid(blk_bvalid), .blk_type(blk_type),
  .blk_last(blk_last), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .byp_valid(byp_valid), .byp_ready(byp_ready),
  .key_out(key_out), .key_update(key_update));

// File: tb/sim_aead_inprep.sv
`timescale 1ns/1ps
module sim_aead_inprep;
  localparam int W = 32;
  localparam int BLK = 128;
  localparam int BB = 16;

  typedef struct {
    logic [BLK-1:0] data;
    logic [BB-1:0]  mask;
    logic           last;
    logic [3:0]     ty;
    logic           dec;
  } blk_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] pub_data = '0, sec_data = '0, byp_data;
  logic pub_valid = 1'b0, sec_valid = 1'b0, blk_ready = 1'b0, byp_ready = 1'b0;
  logic pub_ready, sec_ready, blk_last, blk_valid, byp_valid, key_update, op_decrypt;
  logic [BLK-1:0] blk_data, key_out;
  logic [BB-1:0]  blk_bvalid;
  logic [3:0]     blk_type;

  int checks = 0, errors = 0, upd_cnt = 0;
  logic [W-1:0] pubq[$];
  logic [W-1:0] bypq[$];
  blk_t expq[$];
  logic [7:0] pend[$];
  logic cur_dec = 1'b0;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  aead_inprep #(.W(W), .BLK(BLK), .LENW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .pub_data(pub_data), .pub_valid(pub_valid),
    .pub_ready(pub_ready), .sec_data(sec_data), .sec_valid(sec_valid),
    .sec_ready(sec_ready), .blk_data(blk_data), .blk_bvalid(blk_bvalid),
    .blk_type(blk_type), .blk_last(blk_last), .blk_valid(blk_valid),
    .blk_ready(blk_ready), .byp_data(byp_data), .byp_valid(byp_valid),
    .byp_ready(byp_ready), .key_out(key_out), .key_update(key_update),
    .op_decrypt(op_decrypt));

  task automatic chk(input bit ok, input string req, input logic [BLK-1:0] act, input logic [BLK-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Model: close the pending bytes into an expected block.
  task automatic emit(input bit last, input logic [3:0] ty);
    blk_t b;
    b.data = '0; b.mask = '0; b.last = last; b.ty = ty; b.dec = cur_dec;
    for (int k = 0; k < BB; k++) begin
      if (k < pend.size()) begin
        b.data[BLK-1-8*k -: 8] = pend[k];
        b.mask[BB-1-k] = 1'b1;
      end else if (k == pend.size()) begin
        b.data[BLK-1-8*k -: 8] = 8'h80;
      end
    end
    expq.push_back(b);
    pend.delete();
  endtask

  task automatic instr(input logic [3:0] op);
    pubq.push_back({8'h11, op, 4'h0, 8'h07, 8'h00});
    if (op == 4'b0010) cur_dec = 1'b0;
    if (op == 4'b0011) cur_dec = 1'b1;
  endtask

  task automatic seg(input logic [3:0] ty, input bit eot, input bit eoi, input int len, input int base);
    logic [W-1:0] hdr, wd;
    hdr = {8'h5A, ty, 2'b00, eot, eoi, 16'(len)};
    pubq.push_back(hdr);
    bypq.push_back(hdr);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      for (int j = 0; j < 4; j++) begin
        int idx = w * 4 + j;
        wd[W-1-8*j -: 8] = (idx < len) ? 8'(base + idx * 7) : 8'hEE;
      end
      pubq.push_back(wd);
      if (ty == 4'b0010) bypq.push_back(wd);
    end
    for (int i = 0; i < len; i++) begin
      pend.push_back(8'(base + i * 7));
      if (pend.size() == BB && !(eot && i == len - 1)) emit(1'b0, ty);
    end
    if (eot) emit(1'b1, ty);
  endtask

  task automatic sec_word(input logic [W-1:0] w);
    @(negedge clk);
    sec_valid = 1'b1;
    sec_data  = w;
    #1;
    while (!sec_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic load_key(input logic [BLK-1:0] k);
    sec_word({8'h11, 4'b0100, 4'h0, 8'h03, 8'h00});
    sec_word({8'h11, 4'b0110, 2'b00, 1'b1, 1'b1, 16'd16});
    for (int i = 0; i < 4; i++) sec_word(k[BLK-1-32*i -: 32]);
    @(negedge clk);
    sec_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_pub();
    bit pub_fire = 0, stall = 0;
    blk_t snap;
    int cyc = 0;
    while (pubq.size() > 0 || expq.size() > 0 || bypq.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (pub_fire) void'(pubq.pop_front());
      if (key_update) upd_cnt++;
      if (stall) begin
        chk(blk_valid && blk_data == snap.data && blk_bvalid == snap.mask &&
            blk_last == snap.last && blk_type == snap.ty, "R7 held block",
            blk_data, snap.data);
      end
      pub_valid = (pubq.size() > 0) && ($urandom_range(0, 3) != 0);
      pub_data  = (pubq.size() > 0) ? pubq[0] : '0;
      blk_ready = ($urandom_range(0, 2) != 0);
      byp_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (blk_valid) chk(!pub_ready, "R7 input stalled", BLK'(pub_ready), '0);
      pub_fire = pub_valid && pub_ready;
      stall = blk_valid && !blk_ready;
      if (stall) begin
        snap.data = blk_data; snap.mask = blk_bvalid; snap.last = blk_last; snap.ty = blk_type;
      end
      if (blk_valid && blk_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected block", blk_data, '0);
        end else begin
          blk_t e = expq.pop_front();
          chk(blk_data == e.data, "R3 R4 R5 R6 block data", blk_data, e.data);
          chk(blk_bvalid == e.mask, "R3 R4 R5 byte mask", BLK'(blk_bvalid), BLK'(e.mask));
          chk(blk_last == e.last, "R4 R6 last flag", BLK'(blk_last), BLK'(e.last));
          chk(blk_type == e.ty, "R2 block type", BLK'(blk_type), BLK'(e.ty));
          chk(op_decrypt == e.dec, "R1 R12 direction", BLK'(op_decrypt), BLK'(e.dec));
        end
      end
      if (byp_valid && byp_ready) begin
        chk(pub_fire, "R8 bypass paired with intake", BLK'(pub_fire), BLK'(1));
        if (bypq.size() == 0) chk(1'b0, "R8 unexpected bypass word", BLK'(byp_data), '0);
        else begin
          logic [W-1:0] eb = bypq.pop_front();
          chk(byp_data == eb, "R8 bypass word", BLK'(byp_data), BLK'(eb));
        end
      end
      if (cyc > 50000) begin
        chk(1'b0, "R12 stream did not drain", BLK'(pubq.size()), '0);
        break;
      end
    end
    @(negedge clk);
    pub_valid = 1'b0;
    blk_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    chk(1'b0, "R12 watchdog expired", '0, BLK'(1));
    summary();
  end

  initial begin
    logic [BLK-1:0] k1, k2;
    k1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    k2 = 128'hA5A5_0000_FFFF_1234_5678_9ABC_DEF0_0F0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11
    chk(blk_valid == 0 && byp_valid == 0 && key_update == 0, "R11 reset outputs idle",
        BLK'({blk_valid, byp_valid, key_update}), '0);
    chk(op_decrypt == 0, "R11 reset direction", BLK'(op_decrypt), '0);
    chk(key_out == '0, "R11 reset key", key_out, '0);
    chk(pub_ready == 1, "R11 reset ready", BLK'(pub_ready), BLK'(1));

    load_key(k1);
    chk(key_out == '0, "R9 staged key not active", key_out, '0);

    instr(4'b0101);                // activate
    instr(4'b0000);                // reserved, ignored (R1)
    instr(4'b0010);                // message 1: encrypt
    seg(4'b0001, 1, 0, 16, 8'h10);
    seg(4'b0010, 1, 0, 5,  8'h30);
    seg(4'b0011, 1, 1, 22, 8'h50);
    instr(4'b0011);                // message 2: decrypt
    seg(4'b0001, 1, 0, 16, 8'h21);
    seg(4'b0010, 0, 0, 16, 8'h41);
    seg(4'b0010, 1, 0, 3,  8'h61);
    seg(4'b0100, 0, 0, 0,  8'h00);
    seg(4'b0100, 1, 0, 0,  8'h00);
    seg(4'b0101, 1, 1, 16, 8'h71);
    instr(4'b0010);                // message 3: encrypt
    seg(4'b0001, 1, 0, 12, 8'h05);
    seg(4'b0010, 1, 0, 0,  8'h00);
    seg(4'b0011, 1, 1, 32, 8'h09);
    run_pub();

    chk(key_out == k1, "R10 activated key", key_out, k1);
    chk(upd_cnt == 1, "R10 update pulse count", BLK'(upd_cnt), BLK'(1));
    chk(op_decrypt == 0, "R12 last message direction", BLK'(op_decrypt), '0);

    load_key(k2);
    chk(key_out == k1, "R9 second staging leaves key", key_out, k1);
    chk(key_update == 0, "R9 no pulse on staging", BLK'(key_update), '0);

    instr(4'b0101);
    run_pub();
    chk(key_out == k2, "R10 second activation", key_out, k2);
    chk(upd_cnt == 2, "R10 second pulse", BLK'(upd_cnt), BLK'(2));
    summary();
  end
endmodule